// File: doc/BRIEF.md
# Single-Cycle Subset Processor Core

This block is a 32-bit processor core that completes every instruction in one clock cycle. It supports seven instructions: register add and subtract, OR with an unsigned immediate, word load, word store, branch when two registers are equal, and an absolute jump. Each cycle the core presents its program counter on the fetch port and receives an instruction word. A combinational decoder turns that word into a small set of control strobes. The register file, ALU, immediate extender and operand/write-back multiplexers then work out the result, the data-memory access and the next program counter. The program counter, the register file and the external data memory all update on the same rising edge.

The core is meant to sit between two simple memories. Instruction memory is read-only and addressed by the PC. Data memory has one word-wide port with address, write data, write strobe and combinational read data. Field positions in the instruction word are fixed: opcode in bits 31:26, first source in 25:21, second source in 20:16, destination in 15:11, function code in 5:0, and a 16-bit immediate in 15:0.

Top module: `cpu_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter (the fetch address) to 0.
- R2: Every instruction other than a taken branch or a jump advances the fetch address by exactly 4.
- R3: With opcode 000000, funct 100000 writes rs+rt into rd and funct 100010 writes rs-rt into rd, with 32-bit wraparound.
- R4: Opcode 001101 writes rs OR the zero-extended 16-bit immediate into rt.
- R5: Opcode 100011 loads the data word at rs plus the sign-extended immediate into rt.
- R6: Opcode 101011 writes the rt value to data memory at rs plus the sign-extended immediate, and it writes no register.
- R7: Opcode 000100 compares rs and rt by subtraction. When they are equal, the next fetch address is PC+4 plus the sign-extended immediate times 4; otherwise it is PC+4. It writes neither registers nor memory.
- R8: Opcode 000010 sets the next fetch address to the top 4 bits of PC+4, followed by instruction bits 25:0, followed by two zero bits.
- R9: Register 0 always reads as zero, and writes aimed at it have no effect.
- R10: Any other opcode, or opcode 000000 with any other funct, writes nothing and advances the fetch address by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | DATA_W | Fetch address (program counter) |
| imemData | input | 32 | Instruction word at imemAddr |
| dmemAddr | output | DATA_W | Data-memory word address (ALU result) |
| dmemWdata | output | DATA_W | Store data (rt value) |
| dmemWe | output | 1 | Data-memory write strobe for the current cycle |
| dmemRdata | input | DATA_W | Data word read combinationally at dmemAddr |

## Verification
The bench builds the core with its default parameters: DATA_W=32, REG_NUM=32 and RESET_PC=0. This means the full word width is exercised. A subtraction that goes negative must wrap to 0xFFFFFFFE. An immediate of 0xFFFF must give different upper halves under zero extension and sign extension. A negative load offset must reach below its base register. With the 32-entry file, register 0 can be targeted by a real write and then read back through a store. With reset at 0, the fetch trace can be predicted exactly through a skipped branch, a taken forward branch, a jump, and a branch back onto itself.

// File: rtl/cpu_pkg.sv
package cpu_pkg;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_OR  = 3'd2
  } aluOp_e;

  typedef struct packed {
    logic   regDst;    // 1: destination is rd, 0: rt
    logic   aluSrc;    // 1: second operand is the immediate
    logic   memToReg;  // 1: write back the data-memory word
    logic   regWrite;
    logic   memWrite;
    logic   branch;
    logic   jump;
    logic   signExt;   // 1: sign-extend the immediate, 0: zero-extend
    aluOp_e aluOp;
  } ctrl_t;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

endpackage

// File: rtl/cpu_control.sv
module cpu_control
  import cpu_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctl
);

  logic recognized;

  always_comb begin
    ctl        = '0;
    ctl.aluOp  = ALU_ADD;
    recognized = 1'b1;
    unique case (opcode)
      OP_RTYPE: begin
        if (funct == FN_ADD) begin
          ctl.regDst   = 1'b1;
          ctl.regWrite = 1'b1;
          ctl.aluOp    = ALU_ADD;
        end else if (funct == FN_SUB) begin
          ctl.regDst   = 1'b1;
          ctl.regWrite = 1'b1;
          ctl.aluOp    = ALU_SUB;
        end else begin
          recognized = 1'b0;
        end
      end
      OP_ORI: begin
        ctl.aluSrc   = 1'b1;
        ctl.regWrite = 1'b1;
        ctl.aluOp    = ALU_OR;
      end
      OP_LW: begin
        ctl.aluSrc   = 1'b1;
        ctl.signExt  = 1'b1;
        ctl.memToReg = 1'b1;
        ctl.regWrite = 1'b1;
      end
      OP_SW: begin
        ctl.aluSrc   = 1'b1;
        ctl.signExt  = 1'b1;
        ctl.memWrite = 1'b1;
      end
      OP_BEQ: begin
        ctl.branch  = 1'b1;
        ctl.signExt = 1'b1;
        ctl.aluOp   = ALU_SUB;
      end
      OP_J: begin
        ctl.jump = 1'b1;
      end
      default: recognized = 1'b0;
    endcase
  end

  // R10: undecodable words leave every state-changing strobe low
  always_comb begin
    if (!$isunknown({opcode, funct}) && !recognized) begin
      assert_noop_R10: assert (!ctl.regWrite && !ctl.memWrite && !ctl.branch && !ctl.jump);
    end
  end

endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_NUM = 32,
  localparam int REG_AW = $clog2(REG_NUM)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_AW-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [REG_AW-1:0] raddrA,
  output logic [DATA_W-1:0] rdataA,
  input  logic [REG_AW-1:0] raddrB,
  output logic [DATA_W-1:0] rdataB
);

  logic [DATA_W-1:0] regs [REG_NUM];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdataA = (raddrA == '0) ? '0 : regs[raddrA];
  assign rdataB = (raddrB == '0) ? '0 : regs[raddrB];

  // R9: register 0 reads back as zero even after a write aimed at it
  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    (we && waddr == '0 && raddrA == '0) |=> (raddrA != '0) || (rdataA == '0));

endmodule

// File: rtl/cpu_datapath.sv
module cpu_datapath
  import cpu_pkg::*;
#(
  parameter int              DATA_W   = 32,
  parameter int              REG_NUM  = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctl,
  input  logic [25:0]       instrLow,
  output logic [DATA_W-1:0] imemAddr,
  output logic [DATA_W-1:0] dmemAddr,
  output logic [DATA_W-1:0] dmemWdata,
  output logic              dmemWe,
  input  logic [DATA_W-1:0] dmemRdata
);

  localparam int REG_AW = $clog2(REG_NUM);
  localparam logic [DATA_W-1:0] PC_STEP = DATA_W'(4);

  logic [DATA_W-1:0] pcQ, pcNext, pcPlus4, branchOff, jumpTgt;
  logic [DATA_W-1:0] immExt, rdA, rdB, aluB, aluRes, wbData;
  logic [REG_AW-1:0] rsAddr, rtAddr, rdAddr, wAddr;
  logic [15:0]       imm;
  logic              aluZero, takeBranch;

  assign rsAddr = instrLow[21 +: REG_AW];
  assign rtAddr = instrLow[16 +: REG_AW];
  assign rdAddr = instrLow[11 +: REG_AW];
  assign imm    = instrLow[15:0];

  // Program counter
  always_ff @(posedge clk) begin
    if (rst) pcQ <= RESET_PC;
    else     pcQ <= pcNext;
  end

  assign pcPlus4    = pcQ + PC_STEP;
  assign branchOff  = {immExt[DATA_W-3:0], 2'b00};
  assign jumpTgt    = {pcPlus4[DATA_W-1:28], instrLow, 2'b00};
  assign takeBranch = ctl.branch && aluZero;

  always_comb begin
    if (ctl.jump)       pcNext = jumpTgt;
    else if (takeBranch) pcNext = pcPlus4 + branchOff;
    else                pcNext = pcPlus4;
  end

  // Immediate extender
  assign immExt = ctl.signExt ? {{(DATA_W-16){imm[15]}}, imm}
                              : {{(DATA_W-16){1'b0}}, imm};

  cpu_regfile #(.DATA_W(DATA_W), .REG_NUM(REG_NUM)) i_regfile (
    .clk    (clk),
    .rst    (rst),
    .we     (ctl.regWrite),
    .waddr  (wAddr),
    .wdata  (wbData),
    .raddrA (rsAddr),
    .rdataA (rdA),
    .raddrB (rtAddr),
    .rdataB (rdB)
  );

  // ALU
  assign aluB = ctl.aluSrc ? immExt : rdB;

  always_comb begin
    unique case (ctl.aluOp)
      ALU_SUB: aluRes = rdA - aluB;
      ALU_OR:  aluRes = rdA | aluB;
      default: aluRes = rdA + aluB;
    endcase
  end

  assign aluZero = (aluRes == '0);

  // Write-back and memory port
  assign wAddr     = ctl.regDst ? rdAddr : rtAddr;
  assign wbData    = ctl.memToReg ? dmemRdata : aluRes;
  assign imemAddr  = pcQ;
  assign dmemAddr  = aluRes;
  assign dmemWdata = rdB;
  assign dmemWe    = ctl.memWrite;

  assert_reset_pc_R1: assert property (@(posedge clk)
    rst |=> (imemAddr == RESET_PC));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!ctl.branch && !ctl.jump) |=> (imemAddr == $past(imemAddr) + PC_STEP));

  assert_store_no_reg_R6: assert property (@(posedge clk) disable iff (rst)
    dmemWe |-> !ctl.regWrite);

  assert_branch_target_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl.branch && rdA == rdB) |=>
      (imemAddr == $past(imemAddr) + PC_STEP + $past(branchOff)));

  assert_branch_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    ctl.branch |-> (!dmemWe && !ctl.regWrite));

  assert_jump_target_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.jump |=> (imemAddr[27:0] == {$past(instrLow), 2'b00}));

endmodule

// File: rtl/cpu_core.sv
module cpu_core
  import cpu_pkg::*;
#(
  parameter int                DATA_W   = 32,
  parameter int                REG_NUM  = 32,
  parameter logic [DATA_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] imemAddr,
  input  logic [31:0]       imemData,
  output logic [DATA_W-1:0] dmemAddr,
  output logic [DATA_W-1:0] dmemWdata,
  output logic              dmemWe,
  input  logic [DATA_W-1:0] dmemRdata
);

  ctrl_t ctl;

  cpu_control i_control (
    .opcode (imemData[31:26]),
    .funct  (imemData[5:0]),
    .ctl    (ctl)
  );

  cpu_datapath #(.DATA_W(DATA_W), .REG_NUM(REG_NUM), .RESET_PC(RESET_PC)) i_datapath (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .instrLow  (imemData[25:0]),
    .imemAddr  (imemAddr),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata),
    .dmemWe    (dmemWe),
    .dmemRdata (dmemRdata)
  );

endmodule

// File: tb/test_cpu_core.sv
module test_cpu_core;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 2000;

  typedef struct {
    logic [31:0] addr;
    logic [31:0] data;
    string       req;
  } store_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWdata, dmemRdata;
  logic        dmemWe;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];

  int vectors  = 0;
  int failures = 0;
  bit running  = 1'b0;
  bit done     = 1'b0;

  logic [31:0] expPc [$];
  store_t      expSt [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_core i_cpu_core (
    .clk       (clk),
    .rst       (rst),
    .imemAddr  (imemAddr),
    .imemData  (imemData),
    .dmemAddr  (dmemAddr),
    .dmemWdata (dmemWdata),
    .dmemWe    (dmemWe),
    .dmemRdata (dmemRdata)
  );

  assign imemData  = imem[imemAddr[7:2]];
  assign dmemRdata = dmem[dmemAddr[7:2]];

  always @(posedge clk) begin
    if (dmemWe) dmem[dmemAddr[7:2]] <= dmemWdata;
  end

  function automatic logic [31:0] rType(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] iType(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic pushStore(logic [31:0] a, logic [31:0] d, string r);
    store_t s;
    s.addr = a; s.data = d; s.req = r;
    expSt.push_back(s);
  endtask

  // Monitor: compares fetch trace and stores against the scoreboard
  always @(negedge clk) begin
    if (running && !done) begin
      if (expPc.size() > 0) begin
        logic [31:0] p;
        p = expPc.pop_front();
        check(imemAddr === p, (p == 32'h50 || p == 32'h78) ? "R7/R8" : "R2", imemAddr, p);
      end
      if (dmemWe === 1'b1) begin
        if (expSt.size() == 0) begin
          check(1'b0, "R7 unexpected store", dmemAddr, 32'hFFFF_FFFF);
        end else begin
          store_t s;
          s = expSt.pop_front();
          check(dmemAddr === s.addr, s.req, dmemAddr, s.addr);
          check(dmemWdata === s.data, s.req, dmemWdata, s.data);
        end
      end
    end
  end

  // Driver
  initial begin
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'h0;
      dmem[i] = 32'h0;
    end
    dmem[16] = 32'hCAFE_BABE;

    imem[0]  = iType(6'b001101, 0, 1, 16'h0005);          // r1 = 5
    imem[1]  = iType(6'b001101, 0, 2, 16'h0003);          // r2 = 3
    imem[2]  = rType(1, 2, 3, 6'b100000);                 // r3 = r1 + r2
    imem[3]  = iType(6'b101011, 0, 3, 16'h0000);          // [0] = r3
    imem[4]  = rType(2, 1, 4, 6'b100010);                 // r4 = r2 - r1
    imem[5]  = iType(6'b101011, 0, 4, 16'h0004);
    imem[6]  = iType(6'b001101, 0, 5, 16'hFFFF);          // zero-extended
    imem[7]  = iType(6'b101011, 0, 5, 16'h0008);
    imem[8]  = iType(6'b001101, 0, 0, 16'h1234);          // write to r0
    imem[9]  = iType(6'b101011, 0, 0, 16'h000C);
    imem[10] = iType(6'b100011, 0, 6, 16'h0040);          // r6 = [0x40]
    imem[11] = iType(6'b101011, 0, 6, 16'h0014);
    imem[12] = iType(6'b001101, 0, 7, 16'h0050);          // r7 = 0x50
    imem[13] = iType(6'b100011, 7, 8, 16'hFFF0);          // r8 = [0x40]
    imem[14] = iType(6'b101011, 7, 8, 16'hFFF4);          // [0x44] = r8
    imem[15] = iType(6'b000100, 1, 2, 16'h0005);          // not taken
    imem[16] = iType(6'b101011, 0, 1, 16'h0018);
    imem[17] = iType(6'b000100, 1, 1, 16'h0002);          // taken -> 0x50
    imem[18] = iType(6'b101011, 0, 1, 16'h001C);          // skipped
    imem[19] = iType(6'b101011, 0, 1, 16'h001C);          // skipped
    imem[20] = 32'hFC21_FFFF;                             // unknown opcode
    imem[21] = rType(2, 2, 1, 6'b100101);                 // unknown funct
    imem[22] = iType(6'b101011, 0, 1, 16'h0020);
    imem[23] = {6'b000010, 26'd30};                       // jump -> 0x78
    imem[24] = iType(6'b101011, 0, 1, 16'h0024);          // skipped
    imem[30] = iType(6'b000100, 0, 0, 16'hFFFF);          // branch onto itself

    for (int i = 0; i <= 17; i++) expPc.push_back(32'(i * 4));
    expPc.push_back(32'h50);
    expPc.push_back(32'h54);
    expPc.push_back(32'h58);
    expPc.push_back(32'h5C);
    for (int i = 0; i < 4; i++) expPc.push_back(32'h78);

    pushStore(32'h00, 32'h0000_0008, "R3 add");
    pushStore(32'h04, 32'hFFFF_FFFE, "R3 sub");
    pushStore(32'h08, 32'h0000_FFFF, "R4 zero-extend");
    pushStore(32'h0C, 32'h0000_0000, "R9 r0");
    pushStore(32'h14, 32'hCAFE_BABE, "R5 load");
    pushStore(32'h44, 32'hCAFE_BABE, "R6 store negative offset");
    pushStore(32'h18, 32'h0000_0005, "R7 not taken");
    pushStore(32'h20, 32'h0000_0005, "R10 no-op");

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(imemAddr === 32'h0, "R1 reset", imemAddr, 32'h0);
    @(posedge clk);
    #1;
    rst = 1'b0;
    running = 1'b1;

    while (expPc.size() > 0) @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    check(expSt.size() == 0, "R6 all stores seen", 32'(expSt.size()), 32'h0);
    check(dmem[17] === 32'hCAFE_BABE, "R6 memory content", dmem[17], 32'hCAFE_BABE);
    check(dmem[7] === 32'h0, "R7 skipped store", dmem[7], 32'h0);
    check(dmem[9] === 32'h0, "R8 skipped store", dmem[9], 32'h0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, failures);
    $finish;
  end

  // Watchdog
  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++;
      failures++;
      $display("FAIL watchdog: actual %0d expected 0 pending fetches", expPc.size());
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, failures);
      $finish;
    end
  end

endmodule